// File: doc/BRIEF.md
# Token-Ring Depth-Expanded FIFO

This block builds one deep first-in/first-out queue out of several identical storage slices arranged in a ring. Each slice has a small circular buffer, its own pointers and its own occupancy count. Two ownership tokens move around the ring. The write token marks the slice that accepts new entries, and the read token marks the slice that supplies the oldest entry. A slice accepts a write only while it holds the write token, and it gives up a read only while it holds the read token. When a slice writes or reads its last location, it passes the matching token to the next slice with a one-cycle pulse. The token moves on the same clock edge that the slice drops it.

After reset, one chosen slice holds both tokens and all other slices hold neither. The aggregate full flag is the AND of the slice full flags, and the aggregate empty flag is the AND of the slice empty flags. Read data is show-ahead: the output always presents the head entry of the slice that holds the read token. If the ring is built with a single slice, that slice runs on its own. In that case it honours the rewind input, which moves its read pointer back to location 0, and it drives the half-full output. With two or more slices chained, rewind is ignored and half-full stays low. The reset input is asynchronous and active low, and its release is synchronised to the clock internally.

Top module: `fdr_ring`

## Requirements
- R1: While reset is applied, and after its release until the first write, `empty`=1, `full`=0 and `half_full`=0.
- R2: Entries leave in the order they were written, over any number of laps through all slices.
- R3: A write attempted while `full`=1 is dropped, and later reads return only the entries accepted earlier.
- R4: A read attempted while `empty`=1 has no effect, and a later write followed by a read returns that written value.
- R5: `full`=1 exactly when NUM_SLICES*SLICE_DEPTH entries are held, and `empty`=1 exactly when none are held.
- R6: After writing or reading its location SLICE_DEPTH-1, slice i passes the matching token to slice (i+1) mod NUM_SLICES with a one-cycle pulse, and it no longer holds that token on the next cycle.
- R7: In chained mode (NUM_SLICES>1), pulsing `rewind` has no effect on the stored data or on the read order.
- R8: In chained mode, `half_full` stays 0.
- R9: A read and a write in the same cycle, when the queue is neither full nor empty, both take effect and leave the occupancy unchanged.
- R10: Whenever `empty`=0, `rd_data` shows the oldest entry before any read is requested, and a read (`rd_en`=1 at a clock edge) moves the output to the next entry.
- R11: At every cycle exactly one slice holds the write token and exactly one holds the read token. Slice FIRST_SLICE holds both tokens after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised internally |
| wr_en | input | 1 | Write request, sampled at the rising edge |
| wr_data | input | DW | Entry to write |
| rd_en | input | 1 | Read (pop) request, sampled at the rising edge |
| rewind | input | 1 | Read-pointer rewind, honoured only with a single slice |
| rd_data | output | DW | Oldest entry (show-ahead) |
| full | output | 1 | All slices full |
| empty | output | 1 | All slices empty |
| half_full | output | 1 | More than half occupied (single-slice mode only) |

## Verification
Suppose a token is duplicated, lost or sent to the wrong slice. The ports show it the first time a read crosses a slice boundary: `rd_data` presents an entry out of order, or `empty` or `full` disagrees with the occupancy that is counted at the ports. A pointer that wraps one location early or late shows up in the same way, within one lap of SLICE_DEPTH operations. A miscounted slice occupancy makes `full` or `empty` assert in the wrong cycle. For this reason the bench compares both flags and the head entry against an arithmetic queue model on every cycle. It uses mixed read and write densities over many laps, so each kind of fault is exposed within a few cycles of occurring.

// File: rtl/fdr_pkg.sv
package fdr_pkg;

  typedef struct packed {
    logic wr;
    logic rd;
  } tok_t;

  function automatic int ptr_bits(input int depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction

endpackage

// File: rtl/fdr_slice.sv
module fdr_slice
  import fdr_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int DW      = 9,
  parameter bit CHAINED = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          first_n,
  input  tok_t          tok_in,
  output tok_t          tok_out,
  output tok_t          own,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          rewind,
  output logic [DW-1:0] rd_data,
  output logic          full_s,
  output logic          empty_s,
  output logic          half_s
);

  localparam int PW = ptr_bits(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  tok_t          own_q, own_d, own_rst;
  logic          wr_go, rd_go, rew_go, wrap_w, wrap_r;

  assign full_s  = (cnt_q == CW'(DEPTH));
  assign empty_s = (cnt_q == '0);
  assign wrap_w  = (wptr_q == LAST);
  assign wrap_r  = (rptr_q == LAST);
  assign wr_go   = wr_en & own_q.wr & ~full_s & ~rew_go;
  assign rd_go   = rd_en & own_q.rd & ~empty_s & ~rew_go;
  assign own     = own_q;
  assign rd_data = mem[rptr_q];

  generate
    if (CHAINED) begin : g_chain
      wire unused_rewind = rewind;
      assign tok_out.wr = wr_go & wrap_w;
      assign tok_out.rd = rd_go & wrap_r;
      assign own_d.wr   = (own_q.wr & ~tok_out.wr) | tok_in.wr;
      assign own_d.rd   = (own_q.rd & ~tok_out.rd) | tok_in.rd;
      assign own_rst    = '{wr: ~first_n, rd: ~first_n};
      assign rew_go     = 1'b0;
      assign half_s     = 1'b0;
    end else begin : g_solo
      wire unused_solo = first_n | tok_in.wr | tok_in.rd;
      assign tok_out = '0;
      assign own_d   = '{wr: 1'b1, rd: 1'b1};
      assign own_rst = '{wr: 1'b1, rd: 1'b1};
      assign rew_go  = rewind;
      assign half_s  = (cnt_q > CW'(DEPTH / 2));
    end
  endgenerate

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (wr_go) wptr_d = wrap_w ? '0 : wptr_q + 1'b1;
    if (rd_go) rptr_d = wrap_r ? '0 : rptr_q + 1'b1;
    case ({wr_go, rd_go})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
    if (rew_go) begin
      rptr_d = '0;
      cnt_d  = CW'(wptr_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      own_q  <= own_rst;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
      own_q  <= own_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go) mem[wptr_q] <= wr_data;
  end

endmodule

// File: rtl/fdr_merge.sv
module fdr_merge #(
  parameter int N  = 3,
  parameter int DW = 9
) (
  input  logic [N-1:0]         full_v,
  input  logic [N-1:0]         empty_v,
  input  logic [N-1:0]         rown_v,
  input  logic [N-1:0][DW-1:0] data_v,
  output logic                 full,
  output logic                 empty,
  output logic [DW-1:0]        rd_data
);

  assign full  = &full_v;
  assign empty = &empty_v;

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N; i++) begin
      if (rown_v[i]) rd_data = rd_data | data_v[i];
    end
  end

endmodule

// File: rtl/fdr_ring.sv
module fdr_ring
  import fdr_pkg::*;
#(
  parameter int NUM_SLICES  = 3,
  parameter int SLICE_DEPTH = 4,
  parameter int DW          = 9,
  parameter int FIRST_SLICE = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          rewind,
  output logic [DW-1:0] rd_data,
  output logic          full,
  output logic          empty,
  output logic          half_full
);

  localparam bit CHAINED = (NUM_SLICES > 1);

  logic                         sync0_q, rst_sync_n;
  tok_t                         tok_out_a [NUM_SLICES];
  tok_t                         own_a     [NUM_SLICES];
  logic [NUM_SLICES-1:0]        full_v, empty_v, half_v;
  logic [NUM_SLICES-1:0]        own_w_v, own_r_v, wpass_v, rpass_v;
  logic [NUM_SLICES-1:0][DW-1:0] data_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync0_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      sync0_q    <= 1'b1;
      rst_sync_n <= sync0_q;
    end
  end

  generate
    for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
      localparam int PREV = (i + NUM_SLICES - 1) % NUM_SLICES;
      fdr_slice #(
        .DEPTH   (SLICE_DEPTH),
        .DW      (DW),
        .CHAINED (CHAINED)
      ) u_slice (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .first_n (i != FIRST_SLICE),
        .tok_in  (tok_out_a[PREV]),
        .tok_out (tok_out_a[i]),
        .own     (own_a[i]),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rewind  (rewind),
        .rd_data (data_v[i]),
        .full_s  (full_v[i]),
        .empty_s (empty_v[i]),
        .half_s  (half_v[i])
      );
      assign own_w_v[i] = own_a[i].wr;
      assign own_r_v[i] = own_a[i].rd;
      assign wpass_v[i] = tok_out_a[i].wr;
      assign rpass_v[i] = tok_out_a[i].rd;
    end
  endgenerate

  fdr_merge #(
    .N  (NUM_SLICES),
    .DW (DW)
  ) u_merge (
    .full_v  (full_v),
    .empty_v (empty_v),
    .rown_v  (own_r_v),
    .data_v  (data_v),
    .full    (full),
    .empty   (empty),
    .rd_data (rd_data)
  );

  assign half_full = |half_v;

endmodule

// File: rtl/fdr_ring_chk.sv
module fdr_ring_chk #(
  parameter int N = 3
) (
  input logic         clk,
  input logic         rst_ok,
  input logic         wr_en,
  input logic         rd_en,
  input logic         full,
  input logic         empty,
  input logic         half_full,
  input logic [N-1:0] own_w,
  input logic [N-1:0] own_r,
  input logic [N-1:0] wpass,
  input logic [N-1:0] rpass
);

  a_r11_one_wtoken: assert property (@(posedge clk) disable iff (!rst_ok)
    $countones(own_w) == 1);

  a_r11_one_rtoken: assert property (@(posedge clk) disable iff (!rst_ok)
    $countones(own_r) == 1);

  a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_ok)
    (full && !rd_en) |=> full);

  a_r4_empty_holds: assert property (@(posedge clk) disable iff (!rst_ok)
    (empty && !wr_en) |=> empty);

  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_ok)
    !(full && empty));

  generate
    if (N > 1) begin : g_ring
      a_r8_half_low: assert property (@(posedge clk) disable iff (!rst_ok)
        !half_full);
      for (genvar i = 0; i < N; i++) begin : g_pass
        a_r6_wpass_moves: assert property (@(posedge clk) disable iff (!rst_ok)
          wpass[i] |=> (own_w[(i + 1) % N] && !own_w[i]));
        a_r6_rpass_moves: assert property (@(posedge clk) disable iff (!rst_ok)
          rpass[i] |=> (own_r[(i + 1) % N] && !own_r[i]));
      end
    end
  endgenerate

endmodule

bind fdr_ring fdr_ring_chk #(.N(NUM_SLICES)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .full      (full),
  .empty     (empty),
  .half_full (half_full),
  .own_w     (own_w_v),
  .own_r     (own_r_v),
  .wpass     (wpass_v),
  .rpass     (rpass_v)
);

// File: tb/fdr_ring_tb.sv
`timescale 1ns/1ps
module fdr_ring_tb;

  localparam int NS  = 3;
  localparam int SD  = 4;
  localparam int DW  = 9;
  localparam int CAP = NS * SD;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, rd_en, rewind;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;
  logic          full, empty, half_full;

  int   total = 0;
  int   bad   = 0;
  bit   done  = 1'b0;
  logic [DW-1:0] model_q [$];
  logic [15:0]   lf = 16'hACE1;
  logic [DW-1:0] seq = '0;
  string tag_f = "R5";
  string tag_d = "R2";

  always #2 clk = ~clk;

  fdr_ring #(.NUM_SLICES(NS), .SLICE_DEPTH(SD), .DW(DW), .FIRST_SLICE(0)) u_dut (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_data (wr_data),
    .rd_en (rd_en), .rewind (rewind), .rd_data (rd_data),
    .full (full), .empty (empty), .half_full (half_full)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] lfsr_next(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  // one cycle: check at the falling edge, drive, then update the model after the rising edge
  task automatic cyc(input logic we, input logic re, input logic rw);
    bit acc_w, acc_r;
    @(negedge clk);
    chk(32'(empty), 32'(model_q.size() == 0), tag_f);
    chk(32'(full), 32'(model_q.size() == CAP), tag_f);
    chk(32'(half_full), 32'd0, "R8");
    if (model_q.size() > 0) chk(32'(rd_data), 32'(model_q[0]), tag_d);
    wr_en   = we;
    wr_data = seq;
    rd_en   = re;
    rewind  = rw;
    @(posedge clk);
    acc_w = we && (model_q.size() < CAP);
    acc_r = re && (model_q.size() > 0);
    if (acc_r) void'(model_q.pop_front());
    if (acc_w) model_q.push_back(seq);
    if (we) seq = seq + 9'd37;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; rewind = 1'b0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: flags during reset
    chk(32'(empty), 32'd1, "R1"); chk(32'(full), 32'd0, "R1"); chk(32'(half_full), 32'd0, "R1");
    rst_n = 1'b1;
    tag_f = "R1";
    repeat (4) cyc(1'b0, 1'b0, 1'b0);

    // R11/R10: the first write after reset is shown first, before any read
    tag_f = "R5"; tag_d = "R11";
    cyc(1'b1, 1'b0, 1'b0);
    tag_d = "R10";
    repeat (2) cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 1'b0);

    // R6: fill across every slice, full exactly at CAP, then R3 overflow writes
    tag_f = "R6"; tag_d = "R6";
    repeat (CAP) cyc(1'b1, 1'b0, 1'b0);
    tag_f = "R3"; tag_d = "R3";
    repeat (3) cyc(1'b1, 1'b0, 1'b0);
    repeat (CAP) cyc(1'b0, 1'b1, 1'b0);

    // R4: reads on empty ignored, then one entry round-trips
    tag_f = "R4"; tag_d = "R4";
    repeat (3) cyc(1'b0, 1'b1, 1'b0);
    cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b0);

    // R9: simultaneous read and write at mid occupancy over several laps
    tag_f = "R9"; tag_d = "R9";
    repeat (5) cyc(1'b1, 1'b0, 1'b0);
    repeat (3 * CAP) cyc(1'b1, 1'b1, 1'b0);

    // R7: rewind pulses are ignored while data is held
    tag_f = "R7"; tag_d = "R7";
    cyc(1'b0, 1'b0, 1'b1);
    cyc(1'b0, 1'b1, 1'b1);
    cyc(1'b1, 1'b0, 1'b1);
    repeat (CAP) cyc(1'b0, 1'b1, 1'b0);

    // R2/R5: sweep of write and read densities, with random rewind pulses
    tag_f = "R5"; tag_d = "R2";
    for (int wq = 0; wq < 4; wq++) begin
      for (int rq = 0; rq < 4; rq++) begin
        for (int n = 0; n < 150; n++) begin
          logic we, re, rw;
          lf = lfsr_next(lf); lf = lfsr_next(lf); lf = lfsr_next(lf);
          we = (32'(lf[1:0]) <= wq);
          re = (32'(lf[3:2]) <= rq);
          rw = (lf[9:4] == 6'd0);
          cyc(we, re, rw);
        end
      end
    end
    tag_d = "R2";
    repeat (CAP + 2) cyc(1'b0, 1'b1, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule